// File: doc/BRIEF.md
# Earliest Bank Preparation Mask Unit

This unit decides which banks of a multi-rank memory device can be made ready for a column burst soonest. It looks only at banks that have at least one request waiting. It walks through them one per clock, in rank-major order. For each bank it works out when an activate could issue: straight away once allowed if no row is open, or after a precharge plus the precharge time if a row is open. From that it works out when the column burst could follow.

A bank whose burst can go out by the seamless column deadline is preferred over every bank that cannot. Among non-seamless banks, the earliest activate time wins, and ties are kept. The result is a bit mask of the winning banks. The unit also returns a flag that says whether the activate of the last accepted bank hides behind the traffic already on the data bus.

A scheduler pulses `start` while the unit is idle and holds all bank-state and timing inputs stable until `done` pulses. The results stay valid until the next scan starts.

Top module: `bank_prep_scan`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `best_mask` and `hidden_prep` are all 0.
- R2: A `start` seen while idle raises `busy` on the next clock and begins a scan of NB = RANKS*BANKS_PER_RANK banks, one per clock. With `start` high at clock edge k, `done` is high for exactly one cycle, after edge k+NB, and `busy` is low from then on. A `start` raised while `busy` is high has no effect.
- R3: Only banks whose bit in `waiting_mask` is 1 can appear in `best_mask`. If no bank is waiting, the result is a zero mask with `hidden_prep` = 0.
- R4: A bank's activate time is max(activate-allowed, now) when its `row_open` bit is 0. It is max(precharge-allowed, now) + t_rp when its `row_open` bit is 1. All sums are formed without wrap-around.
- R5: A bank's column time is max(column-allowed, activate time + t_rcd). The bank is seamless when its column time is less than or equal to `col_deadline`.
- R6: The hidden-activate limit is max(col_deadline - t_rcd, now). When col_deadline < t_rcd, the limit is now.
- R7: A waiting bank is accepted when it is seamless. It is also accepted when no seamless bank has been accepted earlier in the scan and its activate time is at or below the running minimum. The running minimum starts above every possible activate time.
- R8: On acceptance, the mask is first cleared if no seamless bank was known before this bank and either this bank is seamless or its activate time is strictly below the running minimum. The bank's bit is then set and the running minimum becomes its activate time.
- R9: `hidden_prep` is 1 when the activate time of the last accepted bank is at or below the hidden-activate limit.
- R10: Bank with rank r and local index b has global id g = r*BANKS_PER_RANK + b. It owns bit g of `waiting_mask`, `row_open` and `best_mask`, and field [g*TW +: TW] of each per-bank time vector. Banks are scanned in increasing g.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (used only when idle) |
| waiting_mask | input | NB | Banks with a waiting request |
| row_open | input | NB | Bank currently has an open row |
| act_allowed | input | NB*TW | Per-bank earliest activate time |
| pre_allowed | input | NB*TW | Per-bank earliest precharge time |
| col_allowed | input | NB*TW | Per-bank earliest column time |
| now_time | input | TW | Current time |
| col_deadline | input | TW | Latest column time that counts as seamless |
| t_rp | input | TW | Precharge duration |
| t_rcd | input | TW | Activate-to-column delay |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at the end of a scan |
| best_mask | output | NB | Banks that can be prepared soonest |
| hidden_prep | output | 1 | Last accepted activate fits behind bus traffic |

## Verification
The bench places a seamless bank after several earlier non-seamless ones. A design that failed to wipe the mask on the first seamless bank would leak those earlier bits into the result. It also places a later non-seamless bank with a smaller activate time after a seamless one. A design that still applied the minimum rule there would replace the seamless choice.

Equal activate times must all be kept, so an off-by-one between `<` and `<=` shows up as a lost or stale bit. Open-row banks must include the precharge time and use the precharge-allowed time, so swapping those shifts the winner. A deadline smaller than t_rcd must give a limit of `now`; a wrapped subtraction would instead report every activate as hidden. Single-bank cases pin down the bit position. A `start` pulse in mid-scan must neither restart the scan nor give a second `done`.

// File: rtl/bprep_pkg.sv
// Shared types for the bank preparation scan.
// Assumes: nothing beyond a two-state scan controller.
package bprep_pkg;
    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;
endpackage

// File: rtl/bprep_sequencer.sv
// Walks the bank index from 0 to NB-1, one step per clock, after a start
// seen while idle, then pulses done for one cycle.
// Assumes: start is ignored while a scan runs.
module bprep_sequencer
    import bprep_pkg::*;
#(
    parameter int NB = 8,
    parameter int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic [IW-1:0] idx,
    output logic          done
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

    scan_state_e state_q;

    // Scan state, bank index and end-of-scan pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCAN_IDLE;
            idx     <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                SCAN_IDLE: begin
                    if (start) begin
                        state_q <= SCAN_RUN;
                        idx     <= '0;
                    end
                end
                default: begin
                    if (idx == LAST_IDX) begin
                        state_q <= SCAN_IDLE;
                        done    <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end

    // Busy flag derived from the state.
    always_comb busy = (state_q == SCAN_RUN);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/bprep_bank_eval.sv
// Combinational timing evaluation of one bank: activate time, seamless
// test against the column deadline, and hidden-activate test.
// Assumes: EW is wide enough that max(TW)+max(TW)+max(TW) does not wrap.
module bprep_bank_eval #(
    parameter int TW = 16,
    parameter int EW = TW + 2
) (
    input  logic          row_open,
    input  logic [TW-1:0] act_allowed,
    input  logic [TW-1:0] pre_allowed,
    input  logic [TW-1:0] col_allowed,
    input  logic [TW-1:0] now_time,
    input  logic [TW-1:0] col_deadline,
    input  logic [TW-1:0] t_rp,
    input  logic [TW-1:0] t_rcd,
    output logic [EW-1:0] act_at,
    output logic          seamless,
    output logic          hidden_ok
);
    logic [EW-1:0] now_e, act_e, pre_e, col_e, dl_e, rp_e, rcd_e;
    logic [EW-1:0] pre_base, col_at, hid_raw, hid_lim;

    // Widen every operand so sums cannot wrap.
    always_comb begin
        now_e = EW'(now_time);
        act_e = EW'(act_allowed);
        pre_e = EW'(pre_allowed);
        col_e = EW'(col_allowed);
        dl_e  = EW'(col_deadline);
        rp_e  = EW'(t_rp);
        rcd_e = EW'(t_rcd);
    end

    // Activate time for closed and open rows.
    always_comb begin
        pre_base = (pre_e > now_e) ? pre_e : now_e;
        if (row_open)
            act_at = pre_base + rp_e;
        else
            act_at = (act_e > now_e) ? act_e : now_e;
    end

    // Earliest column time and the seamless test.
    always_comb begin
        col_at   = (col_e > (act_at + rcd_e)) ? col_e : (act_at + rcd_e);
        seamless = (col_at <= dl_e);
    end

    // Hidden-activate limit, clamped at the current time.
    always_comb begin
        hid_raw   = (dl_e >= rcd_e) ? (dl_e - rcd_e) : '0;
        hid_lim   = (hid_raw > now_e) ? hid_raw : now_e;
        hidden_ok = (act_at <= hid_lim);
    end
endmodule

// File: rtl/bprep_accum.sv
// Folds one evaluated bank per clock into the running result: the
// best-bank mask, the seamless-found flag, the running minimum activate
// time and the hidden flag of the last accepted bank.
// Assumes: clear and step are never high together.
module bprep_accum #(
    parameter int NB = 8,
    parameter int EW = 18,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [IW-1:0] idx,
    input  logic          bank_waiting,
    input  logic [EW-1:0] act_at,
    input  logic          seamless,
    input  logic          hidden_ok,
    output logic [NB-1:0] mask,
    output logic          hidden_prep
);
    logic          found_q;
    logic [EW-1:0] run_min_q;
    logic          accept, wipe;
    logic [NB-1:0] onehot;

    // Acceptance and wipe decisions for the bank under evaluation.
    always_comb begin
        accept = seamless || (!found_q && (act_at <= run_min_q));
        wipe   = !found_q && (seamless || (act_at < run_min_q));
        onehot = NB'(1) << idx;
    end

    // Running result registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            mask        <= '0;
            hidden_prep <= 1'b0;
            found_q     <= 1'b0;
            run_min_q   <= '1;
        end else if (step && bank_waiting && accept) begin
            mask        <= (wipe ? '0 : mask) | onehot;
            found_q     <= found_q | seamless;
            hidden_prep <= hidden_ok;
            run_min_q   <= act_at;
        end
    end

    assert_found_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && found_q) |=> found_q);
    assert_mask_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(mask));
endmodule

// File: rtl/bank_prep_scan.sv
// Top of the earliest bank preparation mask unit. Splits the flat
// per-bank inputs, steps through the banks with the sequencer, evaluates
// the selected bank and accumulates the mask.
// Assumes: all data inputs stay stable from start until done.
module bank_prep_scan #(
    parameter int RANKS          = 2,
    parameter int BANKS_PER_RANK = 4,
    parameter int TW             = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic [RANKS*BANKS_PER_RANK-1:0]       waiting_mask,
    input  logic [RANKS*BANKS_PER_RANK-1:0]       row_open,
    input  logic [RANKS*BANKS_PER_RANK*TW-1:0]    act_allowed,
    input  logic [RANKS*BANKS_PER_RANK*TW-1:0]    pre_allowed,
    input  logic [RANKS*BANKS_PER_RANK*TW-1:0]    col_allowed,
    input  logic [TW-1:0]                         now_time,
    input  logic [TW-1:0]                         col_deadline,
    input  logic [TW-1:0]                         t_rp,
    input  logic [TW-1:0]                         t_rcd,
    output logic                                  busy,
    output logic                                  done,
    output logic [RANKS*BANKS_PER_RANK-1:0]       best_mask,
    output logic                                  hidden_prep
);
    localparam int NB = RANKS * BANKS_PER_RANK;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;
    localparam int EW = TW + 2;

    logic [TW-1:0] act_arr [NB];
    logic [TW-1:0] pre_arr [NB];
    logic [TW-1:0] col_arr [NB];

    // Per-bank field split of the flat time vectors.
    for (genvar g = 0; g < NB; g++) begin : g_split
        assign act_arr[g] = act_allowed[g*TW +: TW];
        assign pre_arr[g] = pre_allowed[g*TW +: TW];
        assign col_arr[g] = col_allowed[g*TW +: TW];
    end

    logic [IW-1:0] idx;
    logic [EW-1:0] act_at;
    logic          seamless, hidden_ok;

    bprep_sequencer #(.NB(NB), .IW(IW)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .idx   (idx),
        .done  (done)
    );

    bprep_bank_eval #(.TW(TW), .EW(EW)) u_eval (
        .row_open     (row_open[idx]),
        .act_allowed  (act_arr[idx]),
        .pre_allowed  (pre_arr[idx]),
        .col_allowed  (col_arr[idx]),
        .now_time     (now_time),
        .col_deadline (col_deadline),
        .t_rp         (t_rp),
        .t_rcd        (t_rcd),
        .act_at       (act_at),
        .seamless     (seamless),
        .hidden_ok    (hidden_ok)
    );

    bprep_accum #(.NB(NB), .EW(EW), .IW(IW)) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (start && !busy),
        .step         (busy),
        .idx          (idx),
        .bank_waiting (waiting_mask[idx]),
        .act_at       (act_at),
        .seamless     (seamless),
        .hidden_ok    (hidden_ok),
        .mask         (best_mask),
        .hidden_prep  (hidden_prep)
    );

    assert_mask_waiting_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((best_mask & ~waiting_mask) == '0));
endmodule

// File: tb/bank_prep_scan_tb.sv
`timescale 1ns/1ps
module bank_prep_scan_tb;
    localparam int RANKS = 2;
    localparam int BPR   = 4;
    localparam int TW    = 16;
    localparam int NB    = RANKS * BPR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NB-1:0]    waiting_mask = '0, row_open = '0;
    logic [NB*TW-1:0] act_allowed = '0, pre_allowed = '0, col_allowed = '0;
    logic [TW-1:0]    now_time = '0, col_deadline = '0, t_rp = '0, t_rcd = '0;
    logic busy, done, hidden_prep;
    logic [NB-1:0] best_mask;

    always #2 clk = ~clk;

    bank_prep_scan #(.RANKS(RANKS), .BANKS_PER_RANK(BPR), .TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .waiting_mask(waiting_mask), .row_open(row_open),
        .act_allowed(act_allowed), .pre_allowed(pre_allowed),
        .col_allowed(col_allowed), .now_time(now_time),
        .col_deadline(col_deadline), .t_rp(t_rp), .t_rcd(t_rcd),
        .busy(busy), .done(done), .best_mask(best_mask),
        .hidden_prep(hidden_prep)
    );

    int n_cmp = 0;
    int n_bad = 0;

    int b_wait[NB], b_open[NB], b_act[NB], b_pre[NB], b_col[NB];
    int now_i, dl_i, rp_i, rcd_i;

    typedef struct {
        int    mask;
        bit    hid;
        string req;
    } exp_t;
    exp_t exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic clear_banks();
        for (int i = 0; i < NB; i++) begin
            b_wait[i] = 0; b_open[i] = 0; b_act[i] = 0; b_pre[i] = 0; b_col[i] = 0;
        end
        now_i = 0; dl_i = 0; rp_i = 0; rcd_i = 0;
    endtask

    // Reference result built from the requirement text.
    function automatic exp_t model(input string req);
        exp_t e;
        int   run_min, act, col, hlim;
        bit   found, seam;
        e.mask = 0; e.hid = 1'b0; e.req = req;
        found = 1'b0; run_min = 32'h7fffffff;
        hlim = (dl_i >= rcd_i) ? dl_i - rcd_i : 0;
        if (now_i > hlim) hlim = now_i;
        for (int g = 0; g < NB; g++) begin
            if (b_wait[g] != 0) begin
                if (b_open[g] != 0) act = ((b_pre[g] > now_i) ? b_pre[g] : now_i) + rp_i;
                else                act = (b_act[g] > now_i) ? b_act[g] : now_i;
                col  = (b_col[g] > act + rcd_i) ? b_col[g] : act + rcd_i;
                seam = (col <= dl_i);
                if (seam || (!found && act <= run_min)) begin
                    if (!found && (seam || act < run_min)) e.mask = 0;
                    found   = found | seam;
                    e.hid   = (act <= hlim);
                    e.mask |= (1 << g);
                    run_min = act;
                end
            end
        end
        return e;
    endfunction

    task automatic apply();
        for (int g = 0; g < NB; g++) begin
            waiting_mask[g] = (b_wait[g] != 0);
            row_open[g]     = (b_open[g] != 0);
            act_allowed[g*TW +: TW] = TW'(b_act[g]);
            pre_allowed[g*TW +: TW] = TW'(b_pre[g]);
            col_allowed[g*TW +: TW] = TW'(b_col[g]);
        end
        now_time = TW'(now_i); col_deadline = TW'(dl_i);
        t_rp = TW'(rp_i); t_rcd = TW'(rcd_i);
    endtask

    // Driver: load inputs, push the expected result, run one scan.
    task automatic run_scan(input string req, input bit poke_mid);
        int cnt;
        @(negedge clk);
        apply();
        exp_q.push_back(model(req));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 100) begin
            if (cnt == 2) chk(busy == 1'b1, "R2", "busy during scan", busy, 1);
            if (poke_mid && cnt == 3) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cnt++;
        end
        chk(cnt == NB + 1, "R2", "done latency", cnt, NB + 1);
        if (poke_mid) begin
            int extra = 0;
            for (int k = 0; k < NB + 3; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk(extra == 0, "R2", "done after mid-scan start", extra, 0);
        end
    endtask

    // Monitor: compare each finished scan with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(int'(best_mask) == e.mask, e.req, "mask", int'(best_mask), e.mask);
                chk(hidden_prep == e.hid, e.req, "hidden_prep", hidden_prep, e.hid);
                chk(!busy, "R2", "busy low at done", busy, 0);
            end
        end
    end

    initial begin
        #(200000 * 4);
        chk(1'b0, "R2", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        clear_banks();
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(best_mask == '0, "R1", "mask in reset", int'(best_mask), 0);
        chk(hidden_prep == 1'b0, "R1", "hidden in reset", hidden_prep, 0);
        rst_n = 1'b1;

        // R3: nothing waiting gives an empty result.
        clear_banks(); now_i = 10; dl_i = 50; rcd_i = 5;
        run_scan("R3", 1'b0);

        // R10: a single waiting bank at rank 1, local bank 1 gives bit 5.
        clear_banks(); b_wait[5] = 1; b_act[5] = 30; dl_i = 10; rcd_i = 4;
        run_scan("R10", 1'b0);
        chk(best_mask == 8'h20, "R10", "bit position", int'(best_mask), 32);

        // R7: ties on activate time among non-seamless closed banks are all kept.
        clear_banks(); now_i = 5; dl_i = 10; rcd_i = 20;
        for (int g = 0; g < NB; g++) begin b_wait[g] = 1; b_act[g] = 40; end
        b_act[2] = 41;
        run_scan("R7", 1'b0);

        // R8: a later seamless bank wipes earlier non-seamless picks.
        clear_banks(); now_i = 0; dl_i = 30; rcd_i = 10;
        b_wait[0] = 1; b_act[0] = 50;
        b_wait[1] = 1; b_act[1] = 50;
        b_wait[4] = 1; b_act[4] = 15;
        b_wait[6] = 1; b_act[6] = 5;
        b_wait[7] = 1; b_act[7] = 60;
        run_scan("R8", 1'b0);

        // R4: open row pays precharge time and uses precharge-allowed time.
        clear_banks(); now_i = 10; dl_i = 12; rcd_i = 6; rp_i = 9;
        b_wait[0] = 1; b_open[0] = 1; b_pre[0] = 12; b_act[0] = 0;
        b_wait[3] = 1; b_act[3] = 20;
        run_scan("R4", 1'b0);

        // R5: column-allowed time can push a bank out of the seamless set.
        clear_banks(); now_i = 0; dl_i = 40; rcd_i = 5;
        b_wait[1] = 1; b_act[1] = 10; b_col[1] = 41;
        b_wait[2] = 1; b_act[2] = 30; b_col[2] = 40;
        run_scan("R5", 1'b0);

        // R6: deadline below t_rcd clamps the hidden limit to now.
        clear_banks(); now_i = 7; dl_i = 3; rcd_i = 8;
        b_wait[4] = 1; b_act[4] = 8;
        run_scan("R6", 1'b0);

        // R9: hidden flag follows the last accepted bank.
        clear_banks(); now_i = 0; dl_i = 100; rcd_i = 10;
        b_wait[0] = 1; b_act[0] = 20;
        b_wait[5] = 1; b_act[5] = 95; b_col[5] = 0;
        b_wait[6] = 1; b_act[6] = 85;
        run_scan("R9", 1'b0);

        // R2: a start during a scan is ignored.
        clear_banks(); now_i = 3; dl_i = 25; rcd_i = 4;
        b_wait[2] = 1; b_act[2] = 9; b_wait[7] = 1; b_act[7] = 9;
        run_scan("R2", 1'b1);

        // R7 R8 R9: varied mixed patterns.
        for (int t = 0; t < 40; t++) begin
            clear_banks();
            now_i = int'($urandom_range(0, 40));
            dl_i  = int'($urandom_range(0, 120));
            rcd_i = int'($urandom_range(0, 30));
            rp_i  = int'($urandom_range(0, 20));
            for (int g = 0; g < NB; g++) begin
                b_wait[g] = int'($urandom_range(0, 1));
                b_open[g] = int'($urandom_range(0, 1));
                b_act[g]  = int'($urandom_range(0, 8)) * 10;
                b_pre[g]  = int'($urandom_range(0, 60));
                b_col[g]  = int'($urandom_range(0, 100));
            end
            run_scan("R7", 1'b0);
        end

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "pending results", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule